// File: doc/BRIEF.md
# Multi-Depth Pixel Unpacker

This block sits between a frame-memory fetch engine and a display pipeline. It accepts 32-bit words on a valid/ready input and produces at most one pixel per clock. The selected pixel depth (8, 16, 24 or 32 bits per pixel) sets how many pixels each word yields. Pixels are taken from the least significant end of each word first. In 24-bit mode a pixel may straddle two words, and the leftover bytes of one word are held over for the next.

Three configuration fields together choose the path: a depth code, a colour interpretation, and an output width flag. The colour field picks between a palette index, passed on to an external palette, and a direct 24-bit RGB value. The width flag either keeps full 8-bit components or reduces them to 6 significant bits for an 18-bit panel. A per-line word count marks the last pixel of each scan line. The configuration is expected to be static between resets. A depth code the block does not support produces no pixels and raises an error flag.

Top module: `pixel_unpacker`

## Requirements
- R1: While reset is held and on the first cycle after it, px_valid and cfg_err are 0 and in_ready is 1.
- R2: With cfg_depth = 2 (8 bpp), each word yields four pixels, taken from bits [7:0] first and bits [31:24] last. Each pixel byte appears on px_index.
- R3: With cfg_depth = 4 (16 bpp), each word yields two pixels, the low halfword first. Red is pixel bits [15:11], green [10:5] and blue [4:0]. Each 5-bit or 6-bit component is widened to 8 bits by appending its own top bits as the low bits, and is placed on px_rgb as red [23:16], green [15:8], blue [7:0].
- R4: With cfg_depth = 6 (24 bpp), three words yield four pixels, taken from consecutive bytes in order across word boundaries. Red, green and blue are pixel bits [23:16], [15:8] and [7:0].
- R5: With cfg_depth = 7 (32 bpp), each word yields one pixel with px_rgb equal to word bits [23:0]. Bits [31:24] are ignored.
- R6: With cfg_colour = 0 (palette), px_rgb is zero for every pixel. With cfg_colour = 4 or 5 (direct) at 8 bpp, px_rgb repeats the pixel byte in all three components.
- R7: With cfg_narrow = 1 (18-bit output), bits [1:0], [9:8] and [17:16] of px_rgb are zero and every other bit equals the 24-bit result.
- R8: cfg_line_words holds words per line minus one. px_eol is 1 exactly on the pixel that uses the last byte of a line's final word, and the next pixel starts a new line.
- R9: With an unsupported depth code (anything other than 2, 4, 6 or 7), in_ready is 1, words are accepted and discarded, no pixel is produced, and cfg_err reads 1 from the cycle after the code is applied.
- R10: A word accepted into an empty unpacker on clock edge k has its first pixel on the outputs after edge k+1.
- R11: in_ready drops while the internal byte store cannot take a whole word. No accepted word is lost, and the pixel order is kept across stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_depth | input | 3 | Depth code: 2, 4, 6, 7 for 8/16/24/32 bpp |
| cfg_colour | input | 3 | Colour mode: 0 palette, 4 direct 8:8:8, 5 direct 16-bit |
| cfg_narrow | input | 1 | 1 selects 18-bit output (components cut to 6 bits) |
| cfg_line_words | input | LW_W | Words per line minus one |
| in_valid | input | 1 | Input word valid |
| in_data | input | 32 | Input word from frame memory |
| in_ready | output | 1 | Unpacker can accept a word this cycle |
| px_valid | output | 1 | Pixel outputs hold a new pixel |
| px_index | output | 8 | Low byte of the pixel (palette index) |
| px_rgb | output | 24 | Expanded colour, red in the top byte |
| px_eol | output | 1 | Pixel is the last of its line |
| cfg_err | output | 1 | Depth code is unsupported |

## Verification
A word accepted on edge k is in the byte store after that edge. Its first pixel is formatted in the next cycle and registered on edge k+1. A further pixel from the store follows on each later edge. The bench shows this directly: it samples at the falling edge after k and expects no pixel, then at the following falling edge and expects the pixel. All other results are gathered by a falling-edge monitor into an ordered capture list and compared once the store has drained. Values are therefore judged by their order, not by a cycle count that stalls would shift. cfg_err is registered, so it is read at least one full cycle after the bad code is applied.

// File: rtl/pxu_pkg.sv
package pxu_pkg;

    localparam logic [2:0] DEP_8  = 3'd2;
    localparam logic [2:0] DEP_16 = 3'd4;
    localparam logic [2:0] DEP_24 = 3'd6;
    localparam logic [2:0] DEP_32 = 3'd7;

    localparam logic [2:0] COL_PALETTE = 3'd0;

    localparam int WORD_BYTES = 4;

    typedef struct packed {
        logic [7:0]  idx;
        logic [23:0] rgb;
    } pix_t;

    // bytes consumed per pixel; 0 marks an unsupported depth
    function automatic logic [2:0] px_bytes(input logic [2:0] depth);
        case (depth)
            DEP_8:   return 3'd1;
            DEP_16:  return 3'd2;
            DEP_24:  return 3'd3;
            DEP_32:  return 3'd4;
            default: return 3'd0;
        endcase
    endfunction

    function automatic logic [7:0] widen5(input logic [4:0] c);
        return {c, c[4:2]};
    endfunction

    function automatic logic [7:0] widen6(input logic [5:0] c);
        return {c, c[5:4]};
    endfunction

endpackage

// File: rtl/pxu_gather.sv
module pxu_gather
    import pxu_pkg::*;
#(
    parameter int BUF_BYTES = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        flush,
    input  logic [2:0]  bpb,
    input  logic        in_valid,
    input  logic [31:0] in_data,
    output logic        in_ready,
    output logic        emit,
    output logic [23:0] head
);
    localparam int CNT_W = $clog2(BUF_BYTES + 1);
    localparam int BUF_W = BUF_BYTES * 8;
    localparam int SH_W  = CNT_W + 3;

    logic [BUF_W-1:0] store_q, store_n, shifted, incoming;
    logic [CNT_W-1:0] cnt_q, cnt_n, take, rem;
    logic             accept;

    always_comb begin
        emit     = !flush && (bpb != 3'd0) && (cnt_q >= CNT_W'(bpb));
        take     = emit ? CNT_W'(bpb) : '0;
        rem      = cnt_q - take;
        in_ready = flush || (rem <= CNT_W'(BUF_BYTES - WORD_BYTES));
        accept   = in_valid && in_ready;
        shifted  = store_q >> SH_W'({take, 3'b000});
        incoming = BUF_W'(in_data) << SH_W'({rem, 3'b000});
        store_n  = accept ? (shifted | incoming) : shifted;
        cnt_n    = rem + (accept ? CNT_W'(WORD_BYTES) : '0);
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            store_q <= '0;
            cnt_q   <= '0;
        end else begin
            store_q <= store_n;
            cnt_q   <= cnt_n;
        end
    end

    assign head = store_q[23:0];

    // R11
    buf_fill_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_W'(BUF_BYTES));

    // R11
    accept_fill_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && !flush) |=> (cnt_q >= CNT_W'(WORD_BYTES)));

endmodule

// File: rtl/pxu_line.sv
module pxu_line #(
    parameter int LW_W = 10
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clr,
    input  logic            step,
    input  logic [2:0]      bpb,
    input  logic [LW_W-1:0] line_words,
    output logic            eol
);
    localparam int LB_W = LW_W + 3;

    logic [LB_W-1:0] pos_q, nxt, line_bytes;

    always_comb begin
        line_bytes = LB_W'({line_words, 2'b00}) + LB_W'(4);
        nxt        = pos_q + LB_W'(bpb);
        eol        = step && (nxt >= line_bytes);
    end

    always_ff @(posedge clk) begin
        if (rst || clr)
            pos_q <= '0;
        else if (step)
            pos_q <= eol ? '0 : nxt;
    end

    // R8
    line_pos_chk: assert property (@(posedge clk) disable iff (rst)
        pos_q < line_bytes);

endmodule

// File: rtl/pxu_format.sv
module pxu_format
    import pxu_pkg::*;
(
    input  logic [23:0] raw,
    input  logic [2:0]  depth,
    input  logic [2:0]  colour,
    input  logic        narrow,
    output pix_t        pix
);
    logic [23:0] full;

    always_comb begin
        case (depth)
            DEP_8:   full = {raw[7:0], raw[7:0], raw[7:0]};
            DEP_16:  full = {widen5(raw[15:11]), widen6(raw[10:5]), widen5(raw[4:0])};
            default: full = raw;
        endcase
        if (colour == COL_PALETTE)
            full = '0;
        if (narrow)
            full = full & 24'hFCFCFC;
        pix.idx = raw[7:0];
        pix.rgb = full;
    end

endmodule

// File: rtl/pixel_unpacker.sv
module pixel_unpacker
    import pxu_pkg::*;
#(
    parameter int LW_W      = 10,
    parameter int BUF_BYTES = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [2:0]      cfg_depth,
    input  logic [2:0]      cfg_colour,
    input  logic            cfg_narrow,
    input  logic [LW_W-1:0] cfg_line_words,
    input  logic            in_valid,
    input  logic [31:0]     in_data,
    output logic            in_ready,
    output logic            px_valid,
    output logic [7:0]      px_index,
    output logic [23:0]     px_rgb,
    output logic            px_eol,
    output logic            cfg_err
);
    logic [2:0]  bpb;
    logic        bad, emit, line_end;
    logic [23:0] head;
    pix_t        fmt;

    assign bpb = px_bytes(cfg_depth);
    assign bad = (bpb == 3'd0);

    pxu_gather #(.BUF_BYTES(BUF_BYTES)) u_gather (
        .clk(clk), .rst(rst), .flush(bad), .bpb(bpb),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .emit(emit), .head(head)
    );

    pxu_line #(.LW_W(LW_W)) u_line (
        .clk(clk), .rst(rst), .clr(bad), .step(emit), .bpb(bpb),
        .line_words(cfg_line_words), .eol(line_end)
    );

    pxu_format u_format (
        .raw(head), .depth(cfg_depth), .colour(cfg_colour),
        .narrow(cfg_narrow), .pix(fmt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            px_valid <= 1'b0;
            px_eol   <= 1'b0;
            px_index <= '0;
            px_rgb   <= '0;
            cfg_err  <= 1'b0;
        end else begin
            px_valid <= emit;
            px_eol   <= emit && line_end;
            cfg_err  <= bad;
            if (emit) begin
                px_index <= fmt.idx;
                px_rgb   <= fmt.rgb;
            end
        end
    end

    // R9
    err_silent_chk: assert property (@(posedge clk) disable iff (rst)
        bad |=> !px_valid);

    // R7
    narrow_chk: assert property (@(posedge clk) disable iff (rst)
        (px_valid && $past(cfg_narrow)) |->
            (px_rgb[1:0] == 2'b00 && px_rgb[9:8] == 2'b00 && px_rgb[17:16] == 2'b00));

    // R6
    palette_chk: assert property (@(posedge clk) disable iff (rst)
        (px_valid && $past(cfg_colour) == 3'd0) |-> (px_rgb == 24'h0));

endmodule

// File: tb/sim_pixel_unpacker.sv
module sim_pixel_unpacker;
    localparam int LW_W = 10;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [2:0]      cfg_depth = 3'd2;
    logic [2:0]      cfg_colour = 3'd0;
    logic            cfg_narrow = 1'b0;
    logic [LW_W-1:0] cfg_line_words = '0;
    logic            in_valid = 1'b0;
    logic [31:0]     in_data = '0;
    logic            in_ready, px_valid, px_eol, cfg_err;
    logic [7:0]      px_index;
    logic [23:0]     px_rgb;

    int nchk = 0;
    int nfail = 0;
    int ncap = 0;
    bit saw_stall = 0;
    logic [23:0] cap_rgb [0:63];
    logic [7:0]  cap_idx [0:63];
    logic        cap_eol [0:63];

    always #10 clk = ~clk;

    pixel_unpacker #(.LW_W(LW_W), .BUF_BYTES(8)) u0 (
        .clk(clk), .rst(rst), .cfg_depth(cfg_depth), .cfg_colour(cfg_colour),
        .cfg_narrow(cfg_narrow), .cfg_line_words(cfg_line_words),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .px_valid(px_valid), .px_index(px_index), .px_rgb(px_rgb),
        .px_eol(px_eol), .cfg_err(cfg_err)
    );

    always @(negedge clk) begin
        if (!rst && px_valid && ncap < 64) begin
            cap_rgb[ncap] = px_rgb;
            cap_idx[ncap] = px_index;
            cap_eol[ncap] = px_eol;
            ncap = ncap + 1;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic start(input logic [2:0] d, input logic [2:0] c, input logic n,
                         input logic [LW_W-1:0] lw);
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0;
        cfg_depth = d; cfg_colour = c; cfg_narrow = n; cfg_line_words = lw;
        @(negedge clk);
        ncap = 0;
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic send(input logic [31:0] w);
        bit done = 0;
        in_valid = 1'b1; in_data = w;
        while (!done) begin
            #1;
            done = in_ready;
            if (!in_ready) saw_stall = 1;
            @(negedge clk);
        end
        in_valid = 1'b0;
    endtask

    task automatic t_reset;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(px_valid == 1'b0, "R1 px_valid in reset", 32'(px_valid), 0);
        check(in_ready == 1'b1, "R1 in_ready in reset", 32'(in_ready), 1);
        rst = 1'b0;
        @(negedge clk);
        check(cfg_err == 1'b0, "R1 cfg_err after reset", 32'(cfg_err), 0);
        check(px_valid == 1'b0, "R1 px_valid after reset", 32'(px_valid), 0);
    endtask

    task automatic t_latency;
        start(3'd7, 3'd4, 1'b0, '0);
        in_valid = 1'b1; in_data = 32'hFFABCDEF;
        #1;
        check(in_ready == 1'b1, "R10 ready when empty", 32'(in_ready), 1);
        @(negedge clk);
        in_valid = 1'b0;
        check(px_valid == 1'b0, "R10 no pixel after edge k", 32'(px_valid), 0);
        @(negedge clk);
        check(px_valid == 1'b1, "R10 pixel after edge k+1", 32'(px_valid), 1);
        check(px_rgb == 24'hABCDEF, "R5 32bpp rgb drops top byte", 32'(px_rgb), 32'hABCDEF);
    endtask

    task automatic t_8bpp_palette;
        logic [7:0] exp_i [0:3];
        exp_i = '{8'hD4, 8'hC3, 8'hB2, 8'hA1};
        start(3'd2, 3'd0, 1'b0, '0);
        send(32'hA1B2C3D4);
        repeat (8) @(negedge clk);
        check(ncap == 4, "R2 pixel count", 32'(ncap), 4);
        for (int i = 0; i < 4; i++) begin
            check(cap_idx[i] == exp_i[i], "R2 index order", 32'(cap_idx[i]), 32'(exp_i[i]));
            check(cap_rgb[i] == 24'h0, "R6 palette rgb zero", 32'(cap_rgb[i]), 0);
            check(cap_eol[i] == (i == 3), "R8 eol single word line", 32'(cap_eol[i]), 32'(i == 3));
        end
    endtask

    task automatic t_8bpp_grey;
        start(3'd2, 3'd4, 1'b0, '0);
        send(32'h0000005A);
        repeat (8) @(negedge clk);
        check(ncap == 4, "R6 grey count", 32'(ncap), 4);
        check(cap_rgb[0] == 24'h5A5A5A, "R6 direct 8bpp grey", 32'(cap_rgb[0]), 32'h5A5A5A);
    endtask

    task automatic t_16bpp;
        start(3'd4, 3'd5, 1'b0, '0);
        send(32'h8410F81F);
        repeat (8) @(negedge clk);
        check(ncap == 2, "R3 pixel count", 32'(ncap), 2);
        check(cap_rgb[0] == 24'hFF00FF, "R3 low halfword", 32'(cap_rgb[0]), 32'hFF00FF);
        check(cap_rgb[1] == 24'h848284, "R3 high halfword widen", 32'(cap_rgb[1]), 32'h848284);
        check(cap_eol[1] == 1'b1, "R8 eol 16bpp", 32'(cap_eol[1]), 1);
    endtask

    task automatic t_24bpp;
        logic [23:0] exp_p [0:3];
        exp_p = '{24'h020100, 24'h050403, 24'h080706, 24'h0B0A09};
        start(3'd6, 3'd4, 1'b0, 10'd2);
        send(32'h03020100);
        send(32'h07060504);
        send(32'h0B0A0908);
        repeat (8) @(negedge clk);
        check(ncap == 4, "R4 pixel count", 32'(ncap), 4);
        for (int i = 0; i < 4; i++) begin
            check(cap_rgb[i] == exp_p[i], "R4 spanning pixel", 32'(cap_rgb[i]), 32'(exp_p[i]));
            check(cap_eol[i] == (i == 3), "R8 eol 24bpp", 32'(cap_eol[i]), 32'(i == 3));
        end
    endtask

    task automatic t_narrow;
        start(3'd7, 3'd4, 1'b1, '0);
        send(32'h00FFFFFF);
        send(32'hAA123456);
        repeat (8) @(negedge clk);
        check(ncap == 2, "R7 pixel count", 32'(ncap), 2);
        check(cap_rgb[0] == 24'hFCFCFC, "R7 narrow white", 32'(cap_rgb[0]), 32'hFCFCFC);
        check(cap_rgb[1] == 24'h103454, "R7 narrow mixed", 32'(cap_rgb[1]), 32'h103454);
    endtask

    task automatic t_stall;
        int bad_i = 0;
        int bad_e = 0;
        start(3'd2, 3'd0, 1'b0, 10'd1);
        saw_stall = 0;
        send(32'h03020100);
        send(32'h07060504);
        send(32'h0B0A0908);
        send(32'h0F0E0D0C);
        repeat (12) @(negedge clk);
        check(saw_stall == 1'b1, "R11 in_ready dropped", 32'(saw_stall), 1);
        check(ncap == 16, "R11 no word lost", 32'(ncap), 16);
        for (int i = 0; i < 16; i++) begin
            if (cap_idx[i] != 8'(i)) bad_i++;
            if (cap_eol[i] != (i == 7 || i == 15)) bad_e++;
        end
        check(bad_i == 0, "R11 order kept across stalls", 32'(bad_i), 0);
        check(bad_e == 0, "R8 eol two word line", 32'(bad_e), 0);
    endtask

    task automatic t_bad_depth;
        start(3'd3, 3'd4, 1'b0, '0);
        send(32'h12345678);
        send(32'h9ABCDEF0);
        repeat (6) @(negedge clk);
        check(ncap == 0, "R9 no pixels", 32'(ncap), 0);
        check(cfg_err == 1'b1, "R9 error flag", 32'(cfg_err), 1);
        check(in_ready == 1'b1, "R9 words accepted", 32'(in_ready), 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL R1 watchdog expired act=0 exp=1");
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        t_reset();
        t_latency();
        t_8bpp_palette();
        t_8bpp_grey();
        t_16bpp();
        t_24bpp();
        t_narrow();
        t_stall();
        t_bad_depth();
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule